// File: doc/BRIEF.md
# General-Purpose Pin Controller with Indirect Drive Configuration

This block controls 29 general-purpose pins, grouped into byte-wide ports of eight pins each. Pin n sits in port n/8 at bit n%8, so the last port holds only five pins. A small register window gives each port an output-value register and an input-level register. The first two ports also have an edge-enable register and a sticky edge-status register, which feed a single interrupt line.

The drive style of each pin is not set in the byte-wide window. Software first writes a pin-select register with a port number and a bit number. It then reads or writes a per-pin drive register that holds three bits: drive enable, push-pull versus open-drain, and pull-up. Inputs pass through a two-stage synchronizer before they are read or used for edge detection.

Register writes take effect on the rising clock edge where `wr_en` is high. Reads are combinational from `addr`. The block holds no state machine: all behaviour comes from register state and the synchronizer pipeline.

Top module: `gpio_ctrl`

## Requirements
- R1: After reset every pad output, drive enable and pull-up is 0, `irq` is 0, and every readable register returns 0.
- R2: The output-value register of port p sits at offset 4p for p<2 and at 8+2(p-2) for p≥2. It reads back what was written. In port 3 only bits 4..0 are stored; bits 7..5 read as 0. Unmapped offsets 0x0C..0x0F read 0.
- R3: The input-level register sits at the output offset plus 1. It returns the pin levels two clock edges after they change, so the value is still old after one edge. Writes to it have no effect.
- R4: The pin-select register (0x10) takes the port number from bits 6..4 and the bit number from bits 2..0, and reads back with bits 7 and 3 at 0. The drive register (0x11) holds bit 0 = drive enable, bit 1 = push-pull (0 = open-drain), bit 2 = pull-up, for the selected pin.
- R5: A pin whose drive-enable bit is 0 has `pad_oe` low, whatever its output value.
- R6: In push-pull mode with drive enabled, `pad_oe` is 1 and `pad_out` equals the output-value bit.
- R7: In open-drain mode with drive enabled, `pad_out` is 0 and `pad_oe` is 1 only while the output-value bit is 0.
- R8: `pad_pu` of a pin equals its pull-up bit.
- R9: When the selected pin index (port*8+bit) is 29 or more, the drive register reads 0 and writes to it change no pin.
- R10: The edge-status register (enable at 4p+2, status at 4p+3, p in 0..1) sets a bit one edge after a rising edge of the synchronized input, only when that bit is enabled. A falling edge, or a rise while disabled, sets nothing.
- R11: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. A new edge in the same cycle wins over the clear.
- R12: `irq` is high exactly when some status bit and its enable bit are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, applied synchronously |
| wr_en | input | 1 | Register write strobe |
| addr | input | 5 | Register offset |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for `addr`, combinational |
| pin_in | input | 29 | Raw pin levels |
| pad_out | output | 29 | Value driven on each pad |
| pad_oe | output | 29 | Pad drive enable |
| pad_pu | output | 29 | Pad pull-up enable |
| irq | output | 1 | Edge interrupt |

## Verification
The hardest case to reach is a drive-register write while the pin-select register points past the last pin. The select field can name 64 pins, but only 29 exist. The stimulus selects port 7 bit 2, and then port 3 bit 6, writes all three drive bits, and then checks that the readback is 0 and that the pull-up and drive-enable outputs are unchanged. It then selects pin 28, the last one, to show that the boundary pin still accepts a write. The edge and interrupt cases are reached by raising one input while its enable is cleared and then while it is set. The bench also masks a pending status with the enable and clears it, and samples the result only after the synchronizer latency has passed.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    typedef struct packed {
        logic pu;
        logic pp;
        logic oe;
    } pin_cfg_t;

    localparam logic [4:0] SEL_ADDR = 5'h10;
    localparam logic [4:0] CFG_ADDR = 5'h11;

    function automatic logic [4:0] dout_addr(input int p);
        return (p < 2) ? 5'(4 * p) : 5'(8 + 2 * (p - 2));
    endfunction

    function automatic logic [4:0] din_addr(input int p);
        return dout_addr(p) + 5'd1;
    endfunction

    function automatic logic [4:0] en_addr(input int p);
        return dout_addr(p) + 5'd2;
    endfunction

    function automatic logic [4:0] sts_addr(input int p);
        return dout_addr(p) + 5'd3;
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W  = 29,
    parameter int EW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [W-1:0]  raw,
    output logic [W-1:0]  lvl,
    output logic [EW-1:0] rise
);
    logic [W-1:0]  s1_q, s2_q;
    logic [EW-1:0] prev_q;
    logic [1:0]    age_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q   <= '0;
            s2_q   <= '0;
            prev_q <= '0;
            age_q  <= '0;
        end else begin
            s1_q   <= raw;
            s2_q   <= s1_q;
            prev_q <= s2_q[EW-1:0];
            if (age_q != 2'd3) age_q <= age_q + 2'd1;
        end
    end

    assign lvl  = s2_q;
    assign rise = s2_q[EW-1:0] & ~prev_q;

    // R3
    sync_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 2'd2) |-> (lvl == $past(raw, 2)));

endmodule

// File: rtl/gpio_evt.sv
module gpio_evt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en_we,
    input  logic         sts_we,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] rise,
    output logic [W-1:0] en_q,
    output logic [W-1:0] sts_q,
    output logic         irq
);
    logic [W-1:0] hit, clr;

    assign hit = rise & en_q;
    assign clr = sts_we ? wdata : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= '0;
            sts_q <= '0;
        end else begin
            if (en_we) en_q <= wdata;
            sts_q <= (sts_q & ~clr) | hit;
        end
    end

    assign irq = |(sts_q & en_q);

    // R10
    evt_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|hit) |=> ((sts_q & $past(hit)) == $past(hit)));

    // R11
    evt_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sts_we |=> ((sts_q & $past(wdata & ~hit)) == '0));

endmodule

// File: rtl/gpio_pincfg.sv
module gpio_pincfg
    import gpio_pkg::*;
#(
    parameter int NPINS = 29
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_we,
    input  logic             cfg_we,
    input  logic [2:0]       sel_port,
    input  logic [2:0]       sel_bit,
    input  logic [2:0]       cfg_wr,
    output logic [7:0]       sel_q,
    output logic [2:0]       cfg_rd,
    output logic [NPINS-1:0] oe,
    output logic [NPINS-1:0] pp,
    output logic [NPINS-1:0] pu
);
    logic [5:0] idx;
    logic       hit;
    pin_cfg_t   cfg_q [NPINS];

    always_ff @(posedge clk) begin
        if (!rst_n) sel_q <= '0;
        else if (sel_we) sel_q <= {1'b0, sel_port, 1'b0, sel_bit};
    end

    assign idx = {sel_q[6:4], sel_q[2:0]};
    assign hit = (int'(idx) < NPINS);

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        always_ff @(posedge clk) begin
            if (!rst_n) cfg_q[i] <= '0;
            else if (cfg_we && hit && idx == 6'(i)) cfg_q[i] <= pin_cfg_t'(cfg_wr);
        end
        assign oe[i] = cfg_q[i].oe;
        assign pp[i] = cfg_q[i].pp;
        assign pu[i] = cfg_q[i].pu;
    end

    always_comb begin
        cfg_rd = '0;
        for (int i = 0; i < NPINS; i++)
            if (hit && idx == 6'(i)) cfg_rd = cfg_q[i];
    end

    // R9
    cfg_oor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !hit) |=> $stable({oe, pp, pu}));

endmodule

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
    import gpio_pkg::*;
#(
    parameter int NPINS = 29
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [4:0]       addr,
    input  logic [7:0]       wr_data,
    output logic [7:0]       rd_data,
    input  logic [NPINS-1:0] pin_in,
    output logic [NPINS-1:0] pad_out,
    output logic [NPINS-1:0] pad_oe,
    output logic [NPINS-1:0] pad_pu,
    output logic             irq
);
    localparam int NPORTS = (NPINS + 7) / 8;
    localparam int PADW   = NPORTS * 8;
    localparam int EVP    = (NPORTS < 2) ? NPORTS : 2;
    localparam int EW     = EVP * 8;

    logic [PADW-1:0]  dout_q;
    logic [PADW-1:0]  lvl_pad;
    logic [NPINS-1:0] lvl;
    logic [EW-1:0]    rise;
    logic [EW-1:0]    en_v, sts_v;
    logic [EVP-1:0]   irq_v;
    logic [NPINS-1:0] cfg_oe, cfg_pp, cfg_pu;
    logic [7:0]       sel_q;
    logic [2:0]       cfg_rd;

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        localparam int VALID = ((NPINS - p * 8) >= 8) ? 8 : (NPINS - p * 8);
        localparam logic [7:0] MASK = 8'((1 << VALID) - 1);
        always_ff @(posedge clk) begin
            if (!rst_n) dout_q[p*8 +: 8] <= '0;
            else if (wr_en && addr == dout_addr(p)) dout_q[p*8 +: 8] <= wr_data & MASK;
        end
    end

    gpio_sync #(.W(NPINS), .EW(EW)) u_sync (
        .clk(clk), .rst_n(rst_n), .raw(pin_in), .lvl(lvl), .rise(rise)
    );
    assign lvl_pad = PADW'(lvl);

    for (genvar p = 0; p < EVP; p++) begin : g_evt
        gpio_evt #(.W(8)) u_evt (
            .clk   (clk),
            .rst_n (rst_n),
            .en_we (wr_en && addr == en_addr(p)),
            .sts_we(wr_en && addr == sts_addr(p)),
            .wdata (wr_data),
            .rise  (rise[p*8 +: 8]),
            .en_q  (en_v[p*8 +: 8]),
            .sts_q (sts_v[p*8 +: 8]),
            .irq   (irq_v[p])
        );
    end
    assign irq = |irq_v;

    gpio_pincfg #(.NPINS(NPINS)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel_we  (wr_en && addr == SEL_ADDR),
        .cfg_we  (wr_en && addr == CFG_ADDR),
        .sel_port(wr_data[6:4]),
        .sel_bit (wr_data[2:0]),
        .cfg_wr  (wr_data[2:0]),
        .sel_q   (sel_q),
        .cfg_rd  (cfg_rd),
        .oe      (cfg_oe),
        .pp      (cfg_pp),
        .pu      (cfg_pu)
    );

    assign pad_out = dout_q[NPINS-1:0] & cfg_pp;
    assign pad_oe  = cfg_oe & (cfg_pp | ~dout_q[NPINS-1:0]);
    assign pad_pu  = cfg_pu;

    always_comb begin
        rd_data = '0;
        for (int p = 0; p < NPORTS; p++) begin
            if (addr == dout_addr(p)) rd_data = dout_q[p*8 +: 8];
            if (addr == din_addr(p))  rd_data = lvl_pad[p*8 +: 8];
        end
        for (int p = 0; p < EVP; p++) begin
            if (addr == en_addr(p))  rd_data = en_v[p*8 +: 8];
            if (addr == sts_addr(p)) rd_data = sts_v[p*8 +: 8];
        end
        if (addr == SEL_ADDR) rd_data = sel_q;
        if (addr == CFG_ADDR) rd_data = {5'b0, cfg_rd};
    end

    // R6
    dout_to_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == dout_addr(0)) |=> (pad_out[7:0] == ($past(wr_data) & cfg_pp[7:0])));

endmodule

// File: tb/sim_gpio_ctrl.sv
module sim_gpio_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  addr = '0;
    logic [7:0]  wr_data = '0;
    logic [7:0]  rd_data;
    logic [28:0] pin_in = '0;
    logic [28:0] pad_out, pad_oe, pad_pu;
    logic        irq;
    int n_chk = 0;
    int n_fail = 0;

    gpio_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
        .rd_data(rd_data), .pin_in(pin_in), .pad_out(pad_out), .pad_oe(pad_oe),
        .pad_pu(pad_pu), .irq(irq)
    );

    always #4 clk = ~clk;

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input logic [4:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        addr = a;
        #1;
        check({24'b0, rd_data}, {24'b0, exp}, tag);
    endtask

    task automatic set_pins(input logic [28:0] v);
        @(negedge clk);
        pin_in = v;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset;
        check({3'b0, pad_oe}, 0, "R1 pad_oe");
        check({3'b0, pad_out}, 0, "R1 pad_out");
        check({3'b0, pad_pu}, 0, "R1 pad_pu");
        check({31'b0, irq}, 0, "R1 irq");
        rd_chk(5'h00, 8'h00, "R1 dout0");
        rd_chk(5'h10, 8'h00, "R1 sel");
        rd_chk(5'h11, 8'h00, "R1 cfg");
    endtask

    task automatic t_dout;
        wr(5'h00, 8'hA5);
        rd_chk(5'h00, 8'hA5, "R2 port0 out");
        wr(5'h08, 8'h3C);
        rd_chk(5'h08, 8'h3C, "R2 port2 out");
        wr(5'h0A, 8'hFF);
        rd_chk(5'h0A, 8'h1F, "R2 port3 upper bits");
        rd_chk(5'h0C, 8'h00, "R2 unmapped");
        wr(5'h00, 8'h00);
        wr(5'h08, 8'h00);
        wr(5'h0A, 8'h00);
    endtask

    task automatic t_din;
        @(negedge clk);
        pin_in = 29'h0AB3C5E7;
        @(negedge clk);
        addr = 5'h01; #1;
        check({24'b0, rd_data}, 32'h00, "R3 one edge still old");
        repeat (2) @(negedge clk);
        rd_chk(5'h01, 8'hE7, "R3 port0 in");
        rd_chk(5'h05, 8'hC5, "R3 port1 in");
        rd_chk(5'h09, 8'hB3, "R3 port2 in");
        rd_chk(5'h0B, 8'h0A, "R3 port3 in");
        wr(5'h01, 8'h00);
        rd_chk(5'h01, 8'hE7, "R3 write ignored");
        set_pins('0);
        rd_chk(5'h03, 8'h00, "R10 rise while disabled");
    endtask

    task automatic t_cfg;
        wr(5'h04, 8'h04);
        wr(5'h10, 8'h12);
        rd_chk(5'h10, 8'h12, "R4 select readback");
        wr(5'h11, 8'h03);
        rd_chk(5'h11, 8'h03, "R4 cfg readback");
        check({31'b0, pad_oe[10]}, 1, "R6 pp oe");
        check({31'b0, pad_out[10]}, 1, "R6 pp out");
        wr(5'h11, 8'h01);
        check({31'b0, pad_oe[10]}, 0, "R7 od high released");
        wr(5'h04, 8'h00);
        check({31'b0, pad_oe[10]}, 1, "R7 od low driven");
        check({31'b0, pad_out[10]}, 0, "R7 od out");
        wr(5'h11, 8'h02);
        check({31'b0, pad_oe[10]}, 0, "R5 tristate low");
        wr(5'h04, 8'h04);
        check({31'b0, pad_oe[10]}, 0, "R5 tristate high");
        wr(5'h11, 8'h04);
        check({3'b0, pad_pu}, 32'h0000_0400, "R8 pullup");
    endtask

    task automatic t_oor;
        wr(5'h10, 8'hFA);
        rd_chk(5'h10, 8'h72, "R4 select reserved bits");
        wr(5'h11, 8'h07);
        rd_chk(5'h11, 8'h00, "R9 oor readback");
        check({3'b0, pad_pu}, 32'h0000_0400, "R9 oor pu");
        check({3'b0, pad_oe}, 0, "R9 oor oe");
        wr(5'h10, 8'h36);
        wr(5'h11, 8'h07);
        rd_chk(5'h11, 8'h00, "R9 pin30 readback");
        check({3'b0, pad_pu}, 32'h0000_0400, "R9 pin30 pu");
        wr(5'h10, 8'h34);
        wr(5'h11, 8'h05);
        rd_chk(5'h11, 8'h05, "R9 pin28 accepted");
        check({31'b0, pad_pu[28]}, 1, "R8 pin28 pu");
        check({31'b0, pad_oe[28]}, 1, "R7 pin28 od low");
    endtask

    task automatic t_evt;
        wr(5'h02, 8'h08);
        set_pins(29'h0000_0008);
        rd_chk(5'h03, 8'h08, "R10 rise sets");
        check({31'b0, irq}, 1, "R12 irq set");
        set_pins(29'h0000_0000);
        rd_chk(5'h03, 8'h08, "R10 fall keeps");
        wr(5'h02, 8'h00);
        check({31'b0, irq}, 0, "R12 irq masked");
        rd_chk(5'h03, 8'h08, "R12 pending kept");
        wr(5'h02, 8'h08);
        check({31'b0, irq}, 1, "R12 irq unmasked");
        wr(5'h03, 8'hF7);
        rd_chk(5'h03, 8'h08, "R11 write zero keeps");
        wr(5'h03, 8'h08);
        rd_chk(5'h03, 8'h00, "R11 clear");
        check({31'b0, irq}, 0, "R12 irq cleared");
        wr(5'h06, 8'h04);
        set_pins(29'h0000_0400);
        rd_chk(5'h07, 8'h04, "R10 port1 rise");
        check({31'b0, irq}, 1, "R12 port1 irq");
        wr(5'h07, 8'h04);
        rd_chk(5'h07, 8'h00, "R11 port1 clear");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_dout();
        t_din();
        t_cfg();
        t_oor();
        t_evt();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #400000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual running expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule